// File: doc/BRIEF.md
# Predicated multi-vector store sequencer

This block turns one decoded request to store 32-bit words from a group of consecutive vector registers into a stream of single-word memory writes. A request names a group size of two or four registers, an encoded first-register field, a 3-bit predicate selector, a 5-bit base selector and a signed 4-bit immediate. The predicate selector picks one of the upper eight predicate registers. That register holds a count of leading active elements across the whole group.

When a request is accepted, the block reads the predicate register and the base in the same cycle. The base comes from the general register file, or from the stack pointer when the selector is 31. From these it works out the start address and the number of active elements. It then walks the group one element at a time. The registers are taken in ascending order and, within each register, the lowest element comes first. Each element sits 4 bytes above the one before it. Each active element produces one write on a valid/ready port, and every write carries a non-temporal hint.

Because the active elements always form a leading run, the walk stops at the last active element. The skipped tail would produce no writes and no state, so nothing outside the block can tell the difference. A misaligned stack-pointer base with at least one active element raises a fault and produces no writes.

Top module: `mvec_store_seq`

## Requirements
- R1: The first register of the group is the encoded register field times 2 for a group of two (`req_quad`=0), or its low three bits times 4 for a group of four (`req_quad`=1). `vrf_idx` steps through the group in ascending order, one register per VLEN/32 elements.
- R2: The start address is base + sign-extended `req_imm` × (registers in group) × (VLEN/32) × 4, modulo 2^64. The base is `sp_value` when `req_rn`=31 and `gpr_data` otherwise, with `gpr_idx`=`req_rn`.
- R3: Element i of the group is written at start + 4·i. Its data is bits [32·e+31:32·e] of register first + i/(VLEN/32), where e = i mod (VLEN/32). Writes are issued in increasing i.
- R4: The active count is the value on `pn_value`, read with `pn_idx` = {1, `req_pg`}, saturated to the group's element total. Exactly elements 0 to count−1 are written, each exactly once, and no other element produces a write.
- R5: When `req_rn`=31, the count is nonzero and `sp_value[3:0]` is not 0, `fault` and `done` pulse together one cycle after acceptance, and no write is issued. A general-register base is never alignment-checked.
- R6: With a zero active count, `done` pulses one cycle after acceptance with `fault` low and no write.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold unchanged on the next cycle.
- R8: `wr_nt` is 1 on every cycle in which `wr_valid` is 1.
- R9: A request is accepted when `req_valid` is high and `busy` is low. When writes follow, `busy` is high from the cycle after acceptance until the last write handshake. `done` pulses for one cycle, in the cycle after that handshake. A `req_valid` raised while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `fault` and `wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_quad | input | 1 | 0: two-register group, 1: four-register group |
| req_zt | input | 4 | Encoded first-register field |
| req_pg | input | 3 | Predicate selector (register 8 + value) |
| req_rn | input | 5 | Base selector; 31 selects the stack pointer |
| req_imm | input | 4 | Signed group-size offset multiplier |
| busy | output | 1 | A write sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle misaligned stack-pointer pulse |
| pn_idx | output | 4 | Predicate register read index |
| pn_value | input | 16 | Predicate register read data (active count) |
| gpr_idx | output | 5 | General register read index |
| gpr_data | input | 64 | General register read data |
| sp_value | input | 64 | Stack pointer value |
| vrf_idx | output | 5 | Vector register read index |
| vrf_data | input | VLEN | Vector register read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 64 | Byte address of the word |
| wr_data | output | 32 | Word to store |
| wr_nt | output | 1 | Non-temporal hint, always set with a write |

## Verification
All three read ports are combinational. The predicate, base and first-register values are therefore taken at the acceptance edge. The first write shows up on the port in the very next cycle, and each later element appears in the cycle after the previous handshake. `done` and `fault` for an empty or faulting request arrive exactly one cycle after acceptance, and `done` for a normal request arrives exactly one cycle after the final handshake. The bench drives inputs on the falling edge and samples shortly after it. It records the iteration of each handshake and requires `done` in the following iteration, or in the very first one when no write is expected.

// File: rtl/mvec_store_pkg.sv
package mvec_store_pkg;

  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam logic [4:0] SP_SEL = 5'd31;

  // First register of the group: field scaled by the group size.
  function automatic logic [4:0] group_first(input logic quad, input logic [3:0] zt);
    return quad ? {zt[2:0], 2'b00} : {zt, 1'b0};
  endfunction

  // Start address: base plus signed multiplier times group footprint.
  function automatic logic [ADDR_W-1:0] group_start(input logic [ADDR_W-1:0] base,
                                                    input logic [3:0] imm,
                                                    input logic [ADDR_W-1:0] grp_bytes);
    logic [ADDR_W-1:0] mult;
    mult = {{(ADDR_W-4){imm[3]}}, imm};
    return base + mult * grp_bytes;
  endfunction

  // Leading-active count limited to the elements present.
  function automatic logic [15:0] sat_count(input logic [15:0] raw, input logic [15:0] total);
    return (raw > total) ? total : raw;
  endfunction

  function automatic logic sp_misaligned(input logic [ADDR_W-1:0] base);
    return base[3:0] != 4'd0;
  endfunction

endpackage

// File: rtl/mvec_addr_gen.sv
module mvec_addr_gen
  import mvec_store_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int CNT_W = 5
) (
  input  logic              quad,
  input  logic [3:0]        zt,
  input  logic [3:0]        imm,
  input  logic [4:0]        rn,
  input  logic [ADDR_W-1:0] gpr_data,
  input  logic [ADDR_W-1:0] sp_value,
  input  logic [15:0]       pn_value,
  output logic [ADDR_W-1:0] start_addr,
  output logic [4:0]        first_reg,
  output logic [CNT_W-1:0]  active_cnt,
  output logic              none_active,
  output logic              sp_fault
);
  localparam int EPR = VLEN / WORD_W;
  localparam int PAIR_BYTES = 2 * EPR * WORD_BYTES;
  localparam int QUAD_BYTES = 4 * EPR * WORD_BYTES;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] grp_bytes;
  logic [15:0]       total;
  logic [15:0]       cnt16;
  logic              use_sp;

  assign use_sp    = (rn == SP_SEL);
  assign base      = use_sp ? sp_value : gpr_data;
  assign grp_bytes = quad ? ADDR_W'(QUAD_BYTES) : ADDR_W'(PAIR_BYTES);
  assign total     = quad ? 16'(4 * EPR) : 16'(2 * EPR);
  assign cnt16     = sat_count(pn_value, total);

  assign start_addr  = group_start(base, imm, grp_bytes);
  assign first_reg   = group_first(quad, zt);
  assign active_cnt  = CNT_W'(cnt16);
  assign none_active = (cnt16 == 16'd0);
  assign sp_fault    = use_sp && !none_active && sp_misaligned(base);

endmodule

// File: rtl/mvec_lane_sel.sv
module mvec_lane_sel
  import mvec_store_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int LG_EPR = 2
) (
  input  logic [VLEN-1:0]   vec,
  input  logic [LG_EPR-1:0] lane,
  output logic [WORD_W-1:0] word
);
  localparam int EPR = VLEN / WORD_W;

  logic [WORD_W-1:0] words [EPR];

  for (genvar g = 0; g < EPR; g++) begin : g_lane
    assign words[g] = vec[g*WORD_W +: WORD_W];
  end

  assign word = words[lane];

endmodule

// File: rtl/mvec_store_ctrl.sv
module mvec_store_ctrl
  import mvec_store_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              start_none,
  input  logic              start_fault,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [4:0]        start_first,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] addr_q,
  output logic [4:0]        first_q,
  output logic [CNT_W-1:0]  elem_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              advance_evt,
  output logic              last_evt
);
  logic busy_q, done_q, fault_q;

  assign advance_evt = busy_q && wr_ready;
  assign last_evt    = advance_evt && (elem_q == cnt_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
      first_q <= '0;
      elem_q  <= '0;
      cnt_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (start_evt) begin
        addr_q  <= start_addr;
        first_q <= start_first;
        elem_q  <= '0;
        cnt_q   <= start_cnt;
        if (start_none) begin
          done_q <= 1'b1;
        end else if (start_fault) begin
          done_q  <= 1'b1;
          fault_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (advance_evt) begin
        if (last_evt) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          elem_q <= elem_q + CNT_W'(1);
          addr_q <= addr_q + ADDR_W'(WORD_BYTES);
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign fault = fault_q;

endmodule

// File: rtl/mvec_store_seq.sv
module mvec_store_seq
  import mvec_store_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_quad,
  input  logic [3:0]      req_zt,
  input  logic [2:0]      req_pg,
  input  logic [4:0]      req_rn,
  input  logic [3:0]      req_imm,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [3:0]      pn_idx,
  input  logic [15:0]     pn_value,
  output logic [4:0]      gpr_idx,
  input  logic [63:0]     gpr_data,
  input  logic [63:0]     sp_value,
  output logic [4:0]      vrf_idx,
  input  logic [VLEN-1:0] vrf_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [63:0]     wr_addr,
  output logic [31:0]     wr_data,
  output logic            wr_nt
);
  localparam int EPR    = VLEN / WORD_W;
  localparam int LG_EPR = $clog2(EPR);
  localparam int CNT_W  = $clog2(4 * EPR + 1);

  // Named events for the checker.
  logic              start_evt;
  logic              advance_evt;
  logic              last_evt;
  logic              none_active;
  logic              sp_fault;
  logic [ADDR_W-1:0] start_addr;
  logic [4:0]        first_reg;
  logic [CNT_W-1:0]  active_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [4:0]        first_q;
  logic [CNT_W-1:0]  elem_idx;
  logic [CNT_W-1:0]  act_cnt_q;

  assign start_evt = req_valid && !busy;
  assign pn_idx    = {1'b1, req_pg};
  assign gpr_idx   = req_rn;

  mvec_addr_gen #(.VLEN(VLEN), .CNT_W(CNT_W)) u_addr (
    .quad       (req_quad),
    .zt         (req_zt),
    .imm        (req_imm),
    .rn         (req_rn),
    .gpr_data   (gpr_data),
    .sp_value   (sp_value),
    .pn_value   (pn_value),
    .start_addr (start_addr),
    .first_reg  (first_reg),
    .active_cnt (active_cnt),
    .none_active(none_active),
    .sp_fault   (sp_fault)
  );

  mvec_store_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .start_none (none_active),
    .start_fault(sp_fault),
    .start_addr (start_addr),
    .start_first(first_reg),
    .start_cnt  (active_cnt),
    .wr_ready   (wr_ready),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .addr_q     (addr_q),
    .first_q    (first_q),
    .elem_q     (elem_idx),
    .cnt_q      (act_cnt_q),
    .advance_evt(advance_evt),
    .last_evt   (last_evt)
  );

  mvec_lane_sel #(.VLEN(VLEN), .LG_EPR(LG_EPR)) u_lane (
    .vec (vrf_data),
    .lane(elem_idx[LG_EPR-1:0]),
    .word(wr_data)
  );

  assign vrf_idx  = first_q + 5'(elem_idx >> LG_EPR);
  assign wr_valid = busy;
  assign wr_addr  = addr_q;
  assign wr_nt    = busy;

endmodule

// File: rtl/mvec_store_chk.sv
module mvec_store_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [63:0]      wr_addr,
  input logic [31:0]      wr_data,
  input logic             wr_nt,
  input logic             start_evt,
  input logic             none_active,
  input logic             last_evt,
  input logic [CNT_W-1:0] elem_idx,
  input logic [CNT_W-1:0] act_cnt_q
);

  // R8
  nt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_nt);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !last_evt |=> wr_valid && (wr_addr == $past(wr_addr) + 64'd4));

  // R4
  active_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> elem_idx < act_cnt_q);

  // R5
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done && !busy && !wr_valid);

  // R6
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && none_active |=> done && !fault && !busy);

  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> done && !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

endmodule

bind mvec_store_seq mvec_store_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_nt      (wr_nt),
  .start_evt  (start_evt),
  .none_active(none_active),
  .last_evt   (last_evt),
  .elem_idx   (elem_idx),
  .act_cnt_q  (act_cnt_q)
);

// File: tb/sim_mvec_store_seq.sv
`timescale 1ns/1ps
module sim_mvec_store_seq;
  localparam int VLEN = 128;
  localparam int EPR  = VLEN / 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_quad = 1'b0;
  logic [3:0]      req_zt = '0;
  logic [2:0]      req_pg = '0;
  logic [4:0]      req_rn = '0;
  logic [3:0]      req_imm = '0;
  logic            busy, done, fault;
  logic [3:0]      pn_idx;
  logic [15:0]     pn_value;
  logic [4:0]      gpr_idx;
  logic [63:0]     gpr_data;
  logic [63:0]     sp_value = '0;
  logic [4:0]      vrf_idx;
  logic [VLEN-1:0] vrf_data;
  logic            wr_valid;
  logic            wr_ready = 1'b0;
  logic [63:0]     wr_addr;
  logic [31:0]     wr_data;
  logic            wr_nt;

  logic [VLEN-1:0] vrf [32];
  logic [63:0]     gpr [32];
  logic [15:0]     pnr [16];

  assign vrf_data = vrf[vrf_idx];
  assign gpr_data = gpr[gpr_idx];
  assign pn_value = pnr[pn_idx];

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mvec_store_seq #(.VLEN(VLEN)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_start(input logic [63:0] base, input logic [3:0] imm,
                                            input bit quad);
    longint k;
    longint nreg;
    k = longint'($signed(imm));
    nreg = quad ? 4 : 2;
    return base + 64'(k * nreg * EPR * 4);
  endfunction

  function automatic int exp_first(input bit quad, input logic [3:0] zt);
    return quad ? int'(zt[2:0]) * 4 : int'(zt) * 2;
  endfunction

  task automatic fill_files();
    for (int r = 0; r < 32; r++) begin
      for (int l = 0; l < EPR; l++)
        vrf[r][l*32 +: 32] = {8'(r), 8'(l), 16'($urandom)};
      gpr[r] = {$urandom, $urandom};
    end
    for (int p = 0; p < 16; p++) pnr[p] = 16'($urandom_range(0, 20));
  endtask

  task automatic run_req(input bit quad, input logic [3:0] zt, input logic [2:0] pg,
                         input logic [4:0] rn, input logic [3:0] imm, input int rdy_pct);
    int total, cnt, exp_n, first, n_wr, last_acc, cyc;
    bit exp_fault, got_done, got_fault, prev_stall, garbage;
    logic [63:0] base, start, prev_addr;
    logic [31:0] prev_data;
    total = quad ? 4 * EPR : 2 * EPR;
    cnt = (int'(pnr[{1'b1, pg}]) > total) ? total : int'(pnr[{1'b1, pg}]);
    base = (rn == 5'd31) ? sp_value : gpr[rn];
    exp_fault = (rn == 5'd31) && (cnt > 0) && (base[3:0] != 4'd0);
    exp_n = exp_fault ? 0 : cnt;
    start = exp_start(base, imm, quad);
    first = exp_first(quad, zt);
    @(negedge clk);
    req_quad = quad; req_zt = zt; req_pg = pg; req_rn = rn; req_imm = imm;
    req_valid = 1'b1;
    @(negedge clk);
    garbage = exp_n > 0;
    req_valid = garbage;
    req_quad = ~quad; req_zt = ~zt; req_pg = ~pg; req_rn = rn ^ 5'd7; req_imm = ~imm;
    n_wr = 0; last_acc = -1; cyc = 0; got_done = 0; got_fault = 0; prev_stall = 0;
    prev_addr = '0; prev_data = '0;
    // R9 busy only when writes follow
    chk(busy == garbage, "R9", "busy after accept", 64'(busy), 64'(garbage));
    while (!got_done && cyc < 400) begin
      if (cyc == 1) req_valid = 1'b0;
      wr_ready = ($urandom_range(0, 99) < rdy_pct);
      #0.5;
      if (prev_stall) begin
        // R7 stalled write holds
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R7", "stall hold",
            wr_addr, prev_addr);
      end
      if (wr_valid) chk(wr_nt == 1'b1, "R8", "nt flag", 64'(wr_nt), 64'd1);
      if (wr_valid && wr_ready) begin
        if (n_wr < exp_n) begin
          int rg, ln;
          rg = first + n_wr / EPR;
          ln = n_wr % EPR;
          // R1 register index in group order
          chk(vrf_idx == 5'(rg), "R1", "vrf index", 64'(vrf_idx), 64'(rg));
          // R2 and R3 address of element
          chk(wr_addr == start + 64'(4 * n_wr), "R3", "address", wr_addr, start + 64'(4 * n_wr));
          chk(wr_data == vrf[rg][ln*32 +: 32], "R3", "data", 64'(wr_data),
              64'(vrf[rg][ln*32 +: 32]));
        end else begin
          // R4 no write past the active count
          chk(1'b0, "R4", "extra write", 64'(n_wr), 64'(exp_n));
        end
        n_wr++;
        last_acc = cyc;
      end
      if (fault) got_fault = 1;
      if (done) begin
        got_done = 1;
        chk(n_wr == exp_n, "R4", "write count", 64'(n_wr), 64'(exp_n));
        chk(got_fault == exp_fault, exp_fault ? "R5" : "R6", "fault", 64'(got_fault),
            64'(exp_fault));
        chk(cyc == last_acc + 1, "R9", "done cycle", 64'(cyc), 64'(last_acc + 1));
        chk(!wr_valid && !busy, "R9", "idle at done", 64'(wr_valid), 64'd0);
      end
      prev_stall = wr_valid && !wr_ready;
      prev_addr = wr_addr;
      prev_data = wr_data;
      @(negedge clk);
      cyc++;
    end
    chk(got_done, "R9", "done seen", 64'(got_done), 64'd1);
    // R9 single pulse
    #0.5;
    chk(!done && !fault, "R9", "done one cycle", 64'(done), 64'd0);
    wr_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    fill_files();
    #1;
    // R10 reset state
    chk(!busy && !done && !fault && !wr_valid, "R10", "reset outputs",
        {busy, done, fault, wr_valid}, 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(!busy && !done && !fault && !wr_valid, "R10", "after reset", 
        {busy, done, fault, wr_valid}, 64'd0);

    // R6 empty predicate
    pnr[9] = 16'd0;
    run_req(1'b0, 4'd3, 3'd1, 5'd4, 4'd2, 100);
    // R6 empty with misaligned stack pointer: no fault
    sp_value = 64'h1000_0007;
    run_req(1'b1, 4'd1, 3'd1, 5'd31, 4'd0, 100);
    // R5 misaligned stack pointer with active elements
    pnr[10] = 16'd3;
    run_req(1'b1, 4'd2, 3'd2, 5'd31, 4'd1, 100);
    // R5 aligned stack pointer writes normally
    sp_value = 64'h0000_8000_0000_1230;
    run_req(1'b0, 4'd15, 3'd2, 5'd31, 4'd15, 70);
    // R4 saturation with a huge count, quad group, negative immediate
    pnr[15] = 16'hFFFF;
    run_req(1'b1, 4'd7, 3'd7, 5'd0, 4'd8, 60);
    // R2 positive immediate at the top of range, pair group
    pnr[8] = 16'd8;
    run_req(1'b0, 4'd0, 3'd0, 5'd30, 4'd7, 50);
    // R3 single active element
    pnr[12] = 16'd1;
    run_req(1'b1, 4'd5, 3'd4, 5'd12, 4'd0, 30);
    // R1 quad group ignores the top field bit
    pnr[13] = 16'd16;
    run_req(1'b1, 4'b1011, 3'd5, 5'd2, 4'd3, 80);

    for (int t = 0; t < 60; t++) begin
      logic [4:0] rn;
      fill_files();
      if (t % 5 == 0) pnr[$urandom_range(8, 15)] = 16'($urandom);
      rn = 5'($urandom);
      sp_value = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) sp_value[3:0] = 4'd0;
      run_req(1'($urandom), 4'($urandom), 3'($urandom), rn, 4'($urandom),
              $urandom_range(20, 100));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule